// File: doc/BRIEF.md
# Multi-channel receiver reset sequencer

This controller brings up an N-lane serial receiver in a safe order. It drives two reset lines that every lane shares: an analog reset for the clock-recovery front end and a digital reset for the datapath behind it. A start pulse asserts both resets. The clock-recovery loops then fall back to the reference clock, which shows as their per-lane lock flags going low.

The analog reset is released only once a data-present input reports traffic at the receiver pins. The loops then move on to lock onto the incoming data. The digital reset stays asserted until every lane reports lock. After that comes a fixed settle time, given in microseconds and turned into system clock cycles. The count starts when the last lane locks. If a lane loses lock during that count, the countdown starts over. If a lane loses lock after the datapath is released, the whole sequence runs again.

All asynchronous status inputs pass through two-flop synchronizers before the state machine uses them. A done flag reports a fully released, fully locked receiver.

Top module: `rxrst_seq`

## Requirements
- R1: While `rst` is high, `ana_rst_o` and `dig_rst_o` are 1 and `done_o` is 0 from the next clock edge on. After `rst` falls, both resets stay at 1 until `start_i` is seen.
- R2: A `start_i` pulse sampled in any state restarts the sequence. Both resets are 1 one clock after the sampling edge.
- R3: In the hold phase that follows a start, the analog reset leaves hold once all synchronized lock flags are 0. If a flag is still 1 after `HOLD_CYC` cycles in hold, the block leaves hold anyway.
- R4: The analog reset falls only while synchronized `data_ok_i` is 1. With the block waiting for data, raising `data_ok_i` makes `ana_rst_o` fall 3 clocks later. While `data_ok_i` stays 0, `ana_rst_o` stays 1.
- R5: `dig_rst_o` falls exactly `CLK_MHZ*SETTLE_US + 3` clocks after the lock input of the last lane rises. The count runs from the last lane, not the first.
- R6: If any lock flag drops during the settle count, the count restarts. The release then happens `CLK_MHZ*SETTLE_US + 3` clocks after all lanes are locked again.
- R7: If any lock input falls while the datapath is released, `ana_rst_o` and `dig_rst_o` both return to 1 three clocks later.
- R8: `done_o` is 1 only when both resets are 0 and all synchronized lock flags are 1. It falls 2 clocks after any lock input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, forces the idle state |
| start_i | input | 1 | Start or restart request, one clock wide, synchronous |
| data_ok_i | input | 1 | Asynchronous indication that data is present at the receiver |
| lock_i | input | N_CH | Asynchronous per-lane frequency-lock flags |
| ana_rst_o | output | 1 | Shared analog receive reset, active high |
| dig_rst_o | output | 1 | Shared digital receive reset, active high |
| done_o | output | 1 | Receiver released and every lane locked |

## Verification
The sequence is run three ways, and each run separates a different exit from the hold phase. In the first, the lock flags are stuck high, so only the timeout can end hold. In the second, the flags drop, so the early exit is taken, and data arrives late, which shows whether the analog release waits for data. In the third, a start arrives mid-run, which shows whether a restart is honoured from any state. The settle count is measured from a staggered lock rise, so counting from the first lane fails the check. A lane drop inside the countdown checks that the count restarts rather than resumes. A drop after release and a reset in mid-run check that both resets come back.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAIT_DATA,
        ST_WAIT_LOCK,
        ST_SETTLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic ana;
        logic dig;
        logic run;
    } rst_ctrl_t;

    function automatic int settle_cycles(input int mhz, input int us);
        return mhz * us;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic rst_ctrl_t decode_state(input seq_state_e st);
        rst_ctrl_t c;
        c.ana = (st == ST_IDLE) || (st == ST_HOLD) || (st == ST_WAIT_DATA);
        c.dig = (st != ST_RUN);
        c.run = (st == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end

endmodule

// File: rtl/rxrst_timer.sv
module rxrst_timer #(
    parameter int MAX_CYC = 256,
    localparam int CW = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] TOP = CW'(MAX_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/rxrst_fsm.sv
module rxrst_fsm
    import rxrst_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int SETTLE_CYC = 500,
    parameter int HOLD_CYC   = 256,
    parameter int CW         = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            data_s_i,
    input  logic [N_CH-1:0] lock_s_i,
    input  logic [CW-1:0]   cnt_i,
    output logic            clr_o,
    output logic            ana_rst_o,
    output logic            dig_rst_o,
    output logic            done_o
);

    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);

    seq_state_e st_q, st_d;
    rst_ctrl_t  ctrl;
    logic       all_lock, none_lock;

    assign all_lock  = &lock_s_i;
    assign none_lock = ~|lock_s_i;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = ST_HOLD;
        end else begin
            case (st_q)
                ST_IDLE:      st_d = ST_IDLE;
                ST_HOLD:      if (none_lock || cnt_i == HOLD_LAST) st_d = ST_WAIT_DATA;
                ST_WAIT_DATA: if (data_s_i) st_d = ST_WAIT_LOCK;
                ST_WAIT_LOCK: if (all_lock) st_d = ST_SETTLE;
                ST_SETTLE: begin
                    if (!all_lock)                 st_d = ST_WAIT_LOCK;
                    else if (cnt_i == SETTLE_LAST) st_d = ST_RUN;
                end
                ST_RUN:       if (!all_lock) st_d = ST_HOLD;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign clr_o     = start_i || (st_d != st_q);
    assign ctrl      = decode_state(st_q);
    assign ana_rst_o = ctrl.ana;
    assign dig_rst_o = ctrl.dig;
    assign done_o    = ctrl.run && all_lock;

    AST_RESET_HOLDS: assert property (@(posedge clk)
        rst |=> ana_rst_o && dig_rst_o && !done_o); // R1
    AST_START_RESETS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ana_rst_o && dig_rst_o); // R2
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> (cnt_i < CW'(HOLD_CYC))); // R3
    AST_ANA_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        $fell(ana_rst_o) |-> $past(data_s_i)); // R4
    AST_DIG_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        $fell(dig_rst_o) |-> ($past(cnt_i) == SETTLE_LAST) && $past(all_lock)); // R5
    AST_SETTLE_ABORT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE && !all_lock && !start_i) |=> (st_q == ST_WAIT_LOCK)); // R6
    AST_LOSS_RESETS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !all_lock) |=> ana_rst_o && dig_rst_o); // R7
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !ana_rst_o && !dig_rst_o && all_lock); // R8

endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
    import rxrst_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int CLK_MHZ   = 125,
    parameter int SETTLE_US = 4,
    parameter int HOLD_CYC  = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            data_ok_i,
    input  logic [N_CH-1:0] lock_i,
    output logic            ana_rst_o,
    output logic            dig_rst_o,
    output logic            done_o
);

    localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
    localparam int MAX_CYC    = max_of(SETTLE_CYC, HOLD_CYC);
    localparam int CW         = $clog2(MAX_CYC + 1);

    logic [N_CH-1:0] lock_s;
    logic            data_s;
    logic            tmr_clr;
    logic [CW-1:0]   tmr_cnt;

    rxrst_sync #(.W(N_CH)) u_sync_lock (
        .clk (clk),
        .rst (rst),
        .d_i (lock_i),
        .q_o (lock_s)
    );

    rxrst_sync #(.W(1)) u_sync_data (
        .clk (clk),
        .rst (rst),
        .d_i (data_ok_i),
        .q_o (data_s)
    );

    rxrst_timer #(.MAX_CYC(MAX_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tmr_clr),
        .cnt_o (tmr_cnt)
    );

    rxrst_fsm #(
        .N_CH       (N_CH),
        .SETTLE_CYC (SETTLE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .data_s_i  (data_s),
        .lock_s_i  (lock_s),
        .cnt_i     (tmr_cnt),
        .clr_o     (tmr_clr),
        .ana_rst_o (ana_rst_o),
        .dig_rst_o (dig_rst_o),
        .done_o    (done_o)
    );

endmodule

// File: tb/sim_rxrst_seq.sv
`timescale 1ns/1ps
module sim_rxrst_seq;

    localparam int NCH = 4;
    localparam int MHZ = 125;
    localparam int SUS = 4;
    localparam int HC  = 32;
    localparam int S   = MHZ * SUS;

    localparam int K_ANA_FALL = 0;
    localparam int K_ANA_RISE = 1;
    localparam int K_DIG_FALL = 2;
    localparam int K_DIG_RISE = 3;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic           data_ok_i = 1'b1;
    logic [NCH-1:0] lock_i = '1;
    logic           ana_rst_o, dig_rst_o, done_o;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   mon_en = 1'b0;
    logic prev_a = 1'b1;
    logic prev_d = 1'b1;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rxrst_seq #(.N_CH(NCH), .CLK_MHZ(MHZ), .SETTLE_US(SUS), .HOLD_CYC(HC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .data_ok_i (data_ok_i),
        .lock_i    (lock_i),
        .ana_rst_o (ana_rst_o),
        .dig_rst_o (dig_rst_o),
        .done_o    (done_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) tick();
    endtask

    task automatic expect_evt(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind;
        e.cyc  = at;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic got_evt(input int kind);
        exp_t e;
        checks++;
        if (q.size() == 0) begin
            failures++;
            $display("FAIL unexpected edge kind=%0d cycle=%0d: actual=edge expected=none", kind, cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.cyc != cyc) begin
                failures++;
                $display("FAIL %s edge: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                         e.req, kind, cyc, e.kind, e.cyc);
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (ana_rst_o !== prev_a) got_evt(ana_rst_o ? K_ANA_RISE : K_ANA_FALL);
            if (dig_rst_o !== prev_d) got_evt(dig_rst_o ? K_DIG_RISE : K_DIG_FALL);
            prev_a = ana_rst_o;
            prev_d = dig_rst_o;
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int k;
        repeat (5) tick();
        @(negedge clk);
        check("R1 reset ana", ana_rst_o, 1'b1);
        check("R1 reset dig", dig_rst_o, 1'b1);
        check("R1 reset done", done_o, 1'b0);
        tick();
        rst = 1'b0;
        mon_en = 1'b1;
        repeat (10) tick();
        @(negedge clk);
        check("R1 idle without start", ana_rst_o, 1'b1);

        // locks stuck high: only the hold timeout can end the hold phase
        tick();
        start_i = 1'b1;
        k = cyc;
        expect_evt(K_ANA_FALL, k + HC + 2, "R3 timeout");
        expect_evt(K_DIG_FALL, k + HC + S + 3, "R5 settle");
        tick();
        start_i = 1'b0;
        wait_until(k + HC + S + 10);
        @(negedge clk);
        check("R8 done after release", done_o, 1'b1);

        // R7: one lane drops after release
        tick();
        lock_i = 4'b1011;
        k = cyc;
        expect_evt(K_ANA_RISE, k + 3, "R7 loss");
        expect_evt(K_DIG_RISE, k + 3, "R7 loss");
        tick();
        @(negedge clk);
        check("R8 done before sync", done_o, 1'b1);
        tick();
        lock_i = '0;
        data_ok_i = 1'b0;
        @(negedge clk);
        check("R8 done drops", done_o, 1'b0);
        repeat (40) tick();
        @(negedge clk);
        check("R4 analog held without data", ana_rst_o, 1'b1);

        // R4: data arrives
        tick();
        data_ok_i = 1'b1;
        k = cyc;
        expect_evt(K_ANA_FALL, k + 3, "R4 data release");
        repeat (10) tick();
        @(negedge clk);
        check("R5 digital held without lock", dig_rst_o, 1'b1);

        // staggered lock rise, then a drop during the countdown
        tick();
        lock_i = 4'b0011;
        repeat (7) tick();
        lock_i = 4'b1111;
        repeat (100) tick();
        lock_i = 4'b1101;
        repeat (5) tick();
        lock_i = 4'b1111;
        k = cyc;
        expect_evt(K_DIG_FALL, k + S + 3, "R6 settle restart");
        wait_until(k + S + 10);
        @(negedge clk);
        check("R8 done after restart", done_o, 1'b1);

        // R2: start in mid-run
        tick();
        start_i = 1'b1;
        k = cyc;
        expect_evt(K_ANA_RISE, k + 1, "R2 restart");
        expect_evt(K_DIG_RISE, k + 1, "R2 restart");
        expect_evt(K_ANA_FALL, k + HC + 2, "R3 timeout again");
        expect_evt(K_DIG_FALL, k + HC + S + 3, "R5 settle again");
        tick();
        start_i = 1'b0;
        wait_until(k + HC + S + 10);

        // R1: reset in mid-run
        tick();
        rst = 1'b1;
        k = cyc;
        expect_evt(K_ANA_RISE, k + 1, "R1 reset");
        expect_evt(K_DIG_RISE, k + 1, "R1 reset");
        tick();
        @(negedge clk);
        check("R1 done in reset", done_o, 1'b0);
        tick();
        rst = 1'b0;
        repeat (20) tick();
        @(negedge clk);
        check("R1 idle ana after reset", ana_rst_o, 1'b1);
        check("R1 idle dig after reset", dig_rst_o, 1'b1);

        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R5 missing edges: actual=%0d pending expected=0", q.size());
        end
        finish_run();
    end

endmodule